// File: doc/BRIEF.md
# Exception Entry and Handler Vector Unit

This unit steers a processor core into a general exception or interrupt handler. On an entry pulse it records where the interrupted program must resume. The resume address is the current PC with the compressed-ISA flag folded into bit 0, moved back over the branch when the faulting instruction sits in a delay slot.

On the same pulse it also captures the 5-bit exception code and the branch-delay flag. It sets the exception-level bit and computes the handler address. That address is built from a boot-time base or the programmable handler base, plus an offset. The offset depends on the kind of event: a general exception, a TLB refill miss, or an interrupt. An interrupt may use a flat entry or a vector table entry chosen by the highest-numbered enabled pending line.

A separate return pulse leaves exception level and jumps back to the saved resume address, restoring the ISA mode kept in its bit 0. The core consumes `new_pc` whenever `new_pc_valid` is high. While `exc_level` is high the core runs in kernel privilege.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After reset, `exc_level`, `cause_bd`, `handler_isa16` and `new_pc_valid` are 0, and `epc_out` and `cause_code` are all zeros.
- R2: On an entry taken with `exc_level` low, `epc_out` becomes `cur_pc` with bit 0 ORed with `isa16`. If `in_delay` is 1, a further 2 is subtracted when `br16` is 1, and 4 when `br16` is 0. `cause_bd` becomes `in_delay`.
- R3: An entry taken while `exc_level` is high leaves `epc_out` and `cause_bd` unchanged.
- R4: Every entry loads `exc_code` into `cause_code` and sets `exc_level`.
- R5: With `bev` high, the handler base is `BOOT_BASE` + 0x200 (default 0xBFC00200). With `bev` low, it is `ebase` with bits 9..0 cleared.
- R6: A general exception (`is_int`=0, `is_refill`=0) uses offset 0x180.
- R7: A refill miss (`is_refill`=1, `is_int`=0) uses offset 0x000 when `exc_level` is low and 0x180 when it is high.
- R8: An interrupt (`is_int`=1) with `vec_en`=1, `bev`=0 and `spacing`≠0 uses offset 0x200 + v·(`spacing`·32). Here v is the index of the highest set bit of `int_pend & int_mask`, or 0 if that value is zero.
- R9: An interrupt with `vec_en`=1 but `bev`=1 or `spacing`=0 uses offset 0x200. An interrupt with `vec_en`=0 uses offset 0x180.
- R10: Entry clears `handler_isa16`. Return sets `new_pc` to `epc_out` with bit 0 cleared, loads `handler_isa16` from `epc_out` bit 0, and clears `exc_level`.
- R11: `new_pc_valid` is high for exactly the one cycle after the clock edge that samples `entry_req` or `ret_req`. If both are high in the same cycle, the entry is taken and the return is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| entry_req | input | 1 | One-cycle request to enter a handler |
| ret_req | input | 1 | One-cycle request to return from a handler |
| exc_code | input | 5 | Exception code to record |
| is_refill | input | 1 | Event is a TLB refill miss |
| is_int | input | 1 | Event is an interrupt |
| cur_pc | input | 32 | PC of the faulting instruction |
| in_delay | input | 1 | Faulting instruction sits in a delay slot |
| br16 | input | 1 | The branch owning the delay slot is 16 bits long |
| isa16 | input | 1 | Core is executing the compressed ISA |
| bev | input | 1 | Boot vectors selected |
| vec_en | input | 1 | Vectored interrupt mode enabled |
| spacing | input | 5 | Vector table spacing in units of 32 bytes |
| int_pend | input | 8 | Pending interrupt lines |
| int_mask | input | 8 | Interrupt enable mask |
| ebase | input | 32 | Programmable handler base |
| exc_level | output | 1 | Exception level (kernel privilege while high) |
| epc_out | output | 32 | Saved resume address |
| cause_bd | output | 1 | Faulting instruction was in a delay slot |
| cause_code | output | 5 | Recorded exception code |
| handler_isa16 | output | 1 | ISA mode to run at `new_pc` |
| new_pc | output | 32 | Address to fetch next |
| new_pc_valid | output | 1 | `new_pc` must be taken this cycle |

## Verification
Every result of this block is registered once. A request sampled at a rising edge therefore shows on `new_pc`, `new_pc_valid`, `epc_out`, `cause_bd`, `cause_code`, `exc_level` and `handler_isa16` right after that same edge, and `new_pc_valid` falls after the next edge. The bench drives requests at the falling edge and reads all outputs one time unit after the rising edge that samples them. It then drops the request and confirms the valid pulse has ended one edge later. Nested entries, returns and same-cycle collisions are sampled at the same point.

// File: rtl/exc_pkg.sv
package exc_pkg;

    localparam int XLEN = 32;

    typedef logic [XLEN-1:0] addr_t;

    // Which kind of handler slot an event lands in
    typedef enum logic [1:0] {
        SLOT_GENERAL   = 2'd0,
        SLOT_REFILL    = 2'd1,
        SLOT_IRQ_FLAT  = 2'd2,
        SLOT_IRQ_TABLE = 2'd3
    } slot_e;

    localparam addr_t OFF_GENERAL  = addr_t'(12'h180);
    localparam addr_t OFF_REFILL   = addr_t'(12'h000);
    localparam addr_t OFF_IRQ      = addr_t'(12'h200);
    localparam addr_t BOOT_ADJUST  = addr_t'(12'h200);
    localparam addr_t EBASE_CLR    = addr_t'(12'h3FF);

    // Address to save for resuming: mode bit folded in, rewound over a branch
    function automatic addr_t resume_addr(addr_t pc, logic isa16, logic in_delay, logic br16);
        addr_t rewind;
        rewind = in_delay ? (br16 ? addr_t'(2) : addr_t'(4)) : '0;
        return (pc | addr_t'(isa16)) - rewind;
    endfunction

endpackage

// File: rtl/exc_resume_pc.sv
module exc_resume_pc
    import exc_pkg::*;
(
    input  addr_t pc,
    input  logic  isa16,
    input  logic  in_delay,
    input  logic  br16,
    output addr_t resume
);

    always_comb begin
        resume = resume_addr(pc, isa16, in_delay, br16);
    end

endmodule

// File: rtl/exc_vector_gen.sv
module exc_vector_gen
    import exc_pkg::*;
#(
    parameter addr_t BOOT_BASE = 32'hBFC0_0000,
    parameter int    NUM_IRQ   = 8,
    parameter int    SPACING_W = 5
) (
    input  logic                 bev,
    input  logic                 exl,
    input  logic                 is_refill,
    input  logic                 is_int,
    input  logic                 vec_en,
    input  logic [SPACING_W-1:0] spacing,
    input  logic [NUM_IRQ-1:0]   int_pend,
    input  logic [NUM_IRQ-1:0]   int_mask,
    input  addr_t                ebase,
    output slot_e                slot,
    output addr_t                target
);

    localparam int IDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

    logic [NUM_IRQ-1:0] live;
    logic [IDX_W-1:0]   top_line;
    addr_t              base;
    addr_t              offset;
    addr_t              stride;

    // Highest-numbered enabled line wins
    always_comb begin
        live     = int_pend & int_mask;
        top_line = '0;
        for (int i = 0; i < NUM_IRQ; i++) begin
            if (live[i]) top_line = IDX_W'(i);
        end
    end

    always_comb begin
        if (is_int) begin
            if (!vec_en)                             slot = SLOT_GENERAL;
            else if (!bev && (spacing != '0))        slot = SLOT_IRQ_TABLE;
            else                                     slot = SLOT_IRQ_FLAT;
        end else if (is_refill && !exl) begin
            slot = SLOT_REFILL;
        end else begin
            slot = SLOT_GENERAL;
        end
    end

    always_comb begin
        base   = bev ? (BOOT_BASE + BOOT_ADJUST) : (ebase & ~EBASE_CLR);
        stride = addr_t'(spacing) << 5;
        unique case (slot)
            SLOT_REFILL:    offset = OFF_REFILL;
            SLOT_IRQ_FLAT:  offset = OFF_IRQ;
            SLOT_IRQ_TABLE: offset = OFF_IRQ + addr_t'(top_line) * stride;
            default:        offset = OFF_GENERAL;
        endcase
        target = base + offset;
    end

endmodule

// File: rtl/exc_state.sv
module exc_state
    import exc_pkg::*;
#(
    parameter int CODE_W = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              entry_req,
    input  logic              ret_req,
    input  logic [CODE_W-1:0] exc_code,
    input  logic              in_delay,
    input  addr_t             resume,
    input  addr_t             target,
    output logic              exl,
    output addr_t             epc,
    output logic              bd,
    output logic [CODE_W-1:0] code,
    output logic              isa16_q,
    output addr_t             pc_q,
    output logic              pc_vld
);

    always_ff @(posedge clk) begin
        if (rst) begin
            exl     <= 1'b0;
            epc     <= '0;
            bd      <= 1'b0;
            code    <= '0;
            isa16_q <= 1'b0;
            pc_q    <= '0;
            pc_vld  <= 1'b0;
        end else begin
            pc_vld <= entry_req | ret_req;
            if (entry_req) begin
                if (!exl) begin
                    epc <= resume;
                    bd  <= in_delay;
                end
                code    <= exc_code;
                exl     <= 1'b1;
                isa16_q <= 1'b0;
                pc_q    <= target;
            end else if (ret_req) begin
                exl     <= 1'b0;
                isa16_q <= epc[0];
                pc_q    <= {epc[XLEN-1:1], 1'b0};
            end
        end
    end

    AST_NESTED_KEEPS_EPC: assert property (@(posedge clk) disable iff (rst)
        (entry_req && exl) |=> ($stable(epc) && $stable(bd))); // R3
    AST_ENTRY_SETS_EXL: assert property (@(posedge clk) disable iff (rst)
        entry_req |=> (exl && (code == $past(exc_code)))); // R4
    AST_ENTRY_ISA32: assert property (@(posedge clk) disable iff (rst)
        entry_req |=> !isa16_q); // R10
    AST_RETURN_LEAVES: assert property (@(posedge clk) disable iff (rst)
        (ret_req && !entry_req) |=> (!exl && (pc_q[0] == 1'b0))); // R10
    AST_PULSE_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        (entry_req || ret_req) |=> pc_vld); // R11
    AST_PULSE_ONLY_ON_REQ: assert property (@(posedge clk) disable iff (rst)
        !(entry_req || ret_req) |=> !pc_vld); // R11

endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
    import exc_pkg::*;
#(
    parameter addr_t BOOT_BASE = 32'hBFC0_0000,
    parameter int    NUM_IRQ   = 8,
    parameter int    SPACING_W = 5,
    parameter int    CODE_W    = 5
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 entry_req,
    input  logic                 ret_req,
    input  logic [CODE_W-1:0]    exc_code,
    input  logic                 is_refill,
    input  logic                 is_int,
    input  logic [XLEN-1:0]      cur_pc,
    input  logic                 in_delay,
    input  logic                 br16,
    input  logic                 isa16,
    input  logic                 bev,
    input  logic                 vec_en,
    input  logic [SPACING_W-1:0] spacing,
    input  logic [NUM_IRQ-1:0]   int_pend,
    input  logic [NUM_IRQ-1:0]   int_mask,
    input  logic [XLEN-1:0]      ebase,
    output logic                 exc_level,
    output logic [XLEN-1:0]      epc_out,
    output logic                 cause_bd,
    output logic [CODE_W-1:0]    cause_code,
    output logic                 handler_isa16,
    output logic [XLEN-1:0]      new_pc,
    output logic                 new_pc_valid
);

    addr_t resume;
    addr_t target;
    slot_e slot;

    exc_resume_pc u_resume (
        .pc       (cur_pc),
        .isa16    (isa16),
        .in_delay (in_delay),
        .br16     (br16),
        .resume   (resume)
    );

    exc_vector_gen #(
        .BOOT_BASE (BOOT_BASE),
        .NUM_IRQ   (NUM_IRQ),
        .SPACING_W (SPACING_W)
    ) u_vec (
        .bev       (bev),
        .exl       (exc_level),
        .is_refill (is_refill),
        .is_int    (is_int),
        .vec_en    (vec_en),
        .spacing   (spacing),
        .int_pend  (int_pend),
        .int_mask  (int_mask),
        .ebase     (ebase),
        .slot      (slot),
        .target    (target)
    );

    exc_state #(
        .CODE_W (CODE_W)
    ) u_state (
        .clk       (clk),
        .rst       (rst),
        .entry_req (entry_req),
        .ret_req   (ret_req),
        .exc_code  (exc_code),
        .in_delay  (in_delay),
        .resume    (resume),
        .target    (target),
        .exl       (exc_level),
        .epc       (epc_out),
        .bd        (cause_bd),
        .code      (cause_code),
        .isa16_q   (handler_isa16),
        .pc_q      (new_pc),
        .pc_vld    (new_pc_valid)
    );

    AST_REFILL_SLOT_NEEDS_EXL_LOW: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_REFILL) |-> (!exc_level && is_refill && !is_int)); // R7
    AST_TABLE_NEEDS_VECTOR_MODE: assert property (@(posedge clk) disable iff (rst)
        (slot == SLOT_IRQ_TABLE) |-> (is_int && vec_en && !bev && (spacing != '0))); // R8

endmodule

// File: tb/test_exc_entry_ctrl.sv
module test_exc_entry_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        entry_req = 0, ret_req = 0;
    logic [4:0]  exc_code = 0;
    logic        is_refill = 0, is_int = 0;
    logic [31:0] cur_pc = 0;
    logic        in_delay = 0, br16 = 0, isa16 = 0;
    logic        bev = 0, vec_en = 0;
    logic [4:0]  spacing = 0;
    logic [7:0]  int_pend = 0, int_mask = 0;
    logic [31:0] ebase = 32'h8000_0000;
    logic        exc_level, cause_bd, handler_isa16, new_pc_valid;
    logic [31:0] epc_out, new_pc;
    logic [4:0]  cause_code;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    exc_entry_ctrl i_exc_entry_ctrl (
        .clk(clk), .rst(rst), .entry_req(entry_req), .ret_req(ret_req),
        .exc_code(exc_code), .is_refill(is_refill), .is_int(is_int),
        .cur_pc(cur_pc), .in_delay(in_delay), .br16(br16), .isa16(isa16),
        .bev(bev), .vec_en(vec_en), .spacing(spacing), .int_pend(int_pend),
        .int_mask(int_mask), .ebase(ebase), .exc_level(exc_level),
        .epc_out(epc_out), .cause_bd(cause_bd), .cause_code(cause_code),
        .handler_isa16(handler_isa16), .new_pc(new_pc), .new_pc_valid(new_pc_valid)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Raise a request at the falling edge, sample just after the rising edge
    task automatic pulse(input bit ent, input bit ret);
        @(negedge clk);
        entry_req = ent;
        ret_req   = ret;
        @(posedge clk);
        #1;
    endtask

    task automatic release_req(input string req);
        @(negedge clk);
        entry_req = 0;
        ret_req   = 0;
        @(posedge clk);
        #1;
        chk(req, "valid pulse ended", 32'(new_pc_valid), 32'd0);
    endtask

    task automatic set_event(input logic [4:0] c, input logic [31:0] pc, input bit dly, input bit b16, input bit i16);
        exc_code = c; cur_pc = pc; in_delay = dly; br16 = b16; isa16 = i16;
    endtask

    task automatic do_return(input logic [31:0] exp_pc, input bit exp_isa);
        pulse(0, 1);
        chk("R10", "return pc", new_pc, exp_pc);
        chk("R10", "return isa16", 32'(handler_isa16), 32'(exp_isa));
        chk("R10", "return exl", 32'(exc_level), 32'd0);
        chk("R11", "return valid", 32'(new_pc_valid), 32'd1);
        release_req("R11");
    endtask

    task automatic t_reset;
        chk("R1", "exl", 32'(exc_level), 0);
        chk("R1", "epc", epc_out, 0);
        chk("R1", "bd", 32'(cause_bd), 0);
        chk("R1", "code", 32'(cause_code), 0);
        chk("R1", "isa16", 32'(handler_isa16), 0);
        chk("R1", "valid", 32'(new_pc_valid), 0);
    endtask

    task automatic t_general_and_nested;
        bev = 0; ebase = 32'h8000_0123; is_int = 0; is_refill = 0;
        set_event(5'd4, 32'h8000_1000, 0, 0, 0);
        pulse(1, 0);
        chk("R6", "general target", new_pc, 32'h8000_0180);
        chk("R2", "epc", epc_out, 32'h8000_1000);
        chk("R2", "bd", 32'(cause_bd), 0);
        chk("R4", "code", 32'(cause_code), 4);
        chk("R4", "exl", 32'(exc_level), 1);
        chk("R11", "entry valid", 32'(new_pc_valid), 1);
        release_req("R11");
        set_event(5'd12, 32'h8000_2004, 1, 0, 0);
        pulse(1, 0);
        chk("R3", "nested epc held", epc_out, 32'h8000_1000);
        chk("R3", "nested bd held", 32'(cause_bd), 0);
        chk("R4", "nested code", 32'(cause_code), 12);
        release_req("R11");
        do_return(32'h8000_1000, 0);
    endtask

    task automatic t_delay_slots;
        ebase = 32'h8000_0000;
        set_event(5'd8, 32'h0040_0104, 1, 0, 0);
        pulse(1, 0);
        chk("R2", "epc 32-bit branch", epc_out, 32'h0040_0100);
        chk("R2", "bd set", 32'(cause_bd), 1);
        release_req("R11");
        do_return(32'h0040_0100, 0);
        set_event(5'd9, 32'h0040_0204, 1, 1, 1);
        pulse(1, 0);
        chk("R2", "epc 16-bit branch", epc_out, 32'h0040_0203);
        chk("R10", "entry isa16 cleared", 32'(handler_isa16), 0);
        release_req("R11");
        do_return(32'h0040_0202, 1);
    endtask

    task automatic t_bev_and_refill;
        bev = 1;
        set_event(5'd10, 32'h0000_3000, 0, 0, 0);
        pulse(1, 0);
        chk("R5", "boot base general", new_pc, 32'hBFC0_0380);
        release_req("R11");
        do_return(32'h0000_3000, 0);
        bev = 0; is_refill = 1;
        set_event(5'd2, 32'h0000_4000, 0, 0, 0);
        pulse(1, 0);
        chk("R7", "refill exl low", new_pc, 32'h8000_0000);
        release_req("R11");
        pulse(1, 0);
        chk("R7", "refill exl high", new_pc, 32'h8000_0180);
        release_req("R11");
        do_return(32'h0000_4000, 0);
        bev = 1;
        pulse(1, 0);
        chk("R5", "boot base refill", new_pc, 32'hBFC0_0200);
        release_req("R11");
        do_return(32'h0000_4000, 0);
        bev = 0; is_refill = 0;
    endtask

    task automatic t_interrupts;
        is_int = 1; vec_en = 1; spacing = 5'd1;
        int_pend = 8'b0010_1000; int_mask = 8'b0000_1111;
        set_event(5'd0, 32'h0000_5000, 0, 0, 0);
        pulse(1, 0);
        chk("R8", "vector 3 spacing 1", new_pc, 32'h8000_0260);
        release_req("R11");
        do_return(32'h0000_5000, 0);
        spacing = 5'd4; int_pend = 8'hFF; int_mask = 8'hFF;
        pulse(1, 0);
        chk("R8", "vector 7 spacing 4", new_pc, 32'h8000_0580);
        release_req("R11");
        do_return(32'h0000_5000, 0);
        int_mask = 8'h00;
        pulse(1, 0);
        chk("R8", "no enabled line", new_pc, 32'h8000_0200);
        release_req("R11");
        do_return(32'h0000_5000, 0);
        spacing = 5'd0; int_mask = 8'hFF;
        pulse(1, 0);
        chk("R9", "spacing zero", new_pc, 32'h8000_0200);
        release_req("R11");
        do_return(32'h0000_5000, 0);
        spacing = 5'd2; bev = 1;
        pulse(1, 0);
        chk("R9", "vectored with bev", new_pc, 32'hBFC0_0400);
        release_req("R11");
        do_return(32'h0000_5000, 0);
        bev = 0; vec_en = 0;
        pulse(1, 0);
        chk("R9", "non-vectored", new_pc, 32'h8000_0180);
        release_req("R11");
        do_return(32'h0000_5000, 0);
        is_int = 0;
    endtask

    task automatic t_collision;
        set_event(5'd13, 32'h0000_6000, 0, 0, 0);
        pulse(1, 1);
        chk("R11", "collision entry wins exl", 32'(exc_level), 1);
        chk("R11", "collision target", new_pc, 32'h8000_0180);
        chk("R11", "collision epc", epc_out, 32'h0000_6000);
        release_req("R11");
        do_return(32'h0000_6000, 0);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        @(posedge clk);
        #1;
        t_reset();
        t_general_and_nested();
        t_delay_slots();
        t_bev_and_refill();
        t_interrupts();
        t_collision();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule